// File: doc/BRIEF.md
# Strided Stream Address Generator

This block walks one vector stream through memory. A scheduler loads a base byte address, an element stride, an element count and an element size with a one-cycle start pulse. The block then offers the addresses of elements 0, 1, 2 and so on, strictly in index order. It moves to the next element each time the scheduler accepts the current one through the advance input.

Every offered address is also split for a word-interleaved memory made of power-of-two one-word-wide banks. The split gives the bank index and the word address inside that bank. From the loaded stride the block also reports two figures that depend only on the stride: how many banks the stream ever touches, and the distance in words between consecutive elements that land in the same bank. A scheduler uses these to judge how well the stream spreads across the banks. A flag marks the final element. A done flag holds once the final element has been taken, and it stays until the next start.

Top module: `stride_addr_gen`

## Requirements
- R1: While reset is applied and in the first cycle after it, `elem_valid` and `done` are both 0.
- R2: In the cycle after `start` is high, `elem_valid` is 1 and `elem_addr` equals `cfg_base`, provided `cfg_len` is nonzero. This holds from any prior state, including mid-stream and done.
- R3: When `elem_valid` and `adv` are both high and the element is not the last, the next cycle's `elem_addr` is the previous one plus `cfg_stride * 2^cfg_size`, modulo 2^ADDR_W. Without `adv`, every element output holds its value.
- R4: `elem_last` is 1 exactly while element number `cfg_len-1` is offered. Accepting that element makes `elem_valid` 0 and `done` 1 in the next cycle. `done` then stays 1 with `elem_valid` 0 until the next `start`, and `elem_valid` and `done` are never 1 together.
- R5: A start with `cfg_len` = 0 gives `done` = 1 and `elem_valid` = 0 in the next cycle.
- R6: The word address is `elem_addr >> log2(WORD_BYTES)`. `elem_bank` is the word address modulo NUM_BANKS, which is its low bits. `elem_offset` is the word address divided by NUM_BANKS.
- R7: From the cycle after a start, `banks_used` = NUM_BANKS / g and `intra_stride` = stride / g, where g = gcd(NUM_BANKS, stride). A stride of 0 gives g = NUM_BANKS, so `banks_used` = 1 and `intra_stride` = 0. After reset, both outputs read as they would for stride 0.
- R8: A stride of 0 offers `cfg_base` for every one of the `cfg_len` elements.
- R9: When `start` and `adv` are high in the same cycle, `start` wins. The next cycle offers element 0 of the new stream.
- R10: `adv` while `elem_valid` is 0 has no effect. After a stream ends, `done` stays 1 and `elem_addr` keeps the last element's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Loads the configuration and restarts the stream |
| cfg_base | input | ADDR_W | Byte address of element 0 |
| cfg_stride | input | STRIDE_W | Stride in elements (unsigned) |
| cfg_len | input | LEN_W | Number of elements |
| cfg_size | input | SIZE_W | log2 of the element size in bytes |
| adv | input | 1 | Scheduler accepts the offered element |
| elem_valid | output | 1 | An element address is offered |
| elem_addr | output | ADDR_W | Byte address of the offered element |
| elem_bank | output | BANK_W | Bank index of the offered element |
| elem_offset | output | OFF_W | Word address inside the bank |
| elem_last | output | 1 | The offered element is the final one |
| done | output | 1 | Stream finished; held until the next start |
| banks_used | output | BANK_BITS+1 | Number of distinct banks the stream touches |
| intra_stride | output | STRIDE_W | Effective stride in words inside one bank |

## Verification
Every result is registered once: the element outputs, the stride figures and `done` all change in the first cycle after the `start` or `adv` edge that causes them, and they are combinational splits of that registered state. The bench drives inputs on the falling edge. At each rising edge it steps a behavioural integer model, and it compares every output 1 ns later, so each comparison falls exactly one cycle after its stimulus. Directed checks for restart priority, zero length, zero stride and ignored advances sample on the falling edge that follows the edge which should have acted.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sag_bank_geom.sv
module sag_bank_geom #(
    parameter int STRIDE_W  = 16,
    parameter int NUM_BANKS = 8,
    localparam int BANK_BITS = $clog2(NUM_BANKS)
) (
    input  logic [STRIDE_W-1:0]  stride,
    output logic [BANK_BITS:0]   banks_used,
    output logic [STRIDE_W-1:0]  intra_stride
);

    // gcd with a power-of-two bank count: lowest set bit of the stride, capped
    int gcd_log;

    always_comb begin
        gcd_log = BANK_BITS;
        for (int i = BANK_BITS - 1; i >= 0; i--) begin
            if (stride[i]) gcd_log = i;
        end
        banks_used   = (BANK_BITS + 1)'(NUM_BANKS) >> gcd_log;
        intra_stride = stride >> gcd_log;
    end

endmodule

// File: rtl/sag_addr_split.sv
module sag_addr_split #(
    parameter int ADDR_W     = 32,
    parameter int NUM_BANKS  = 8,
    parameter int WORD_BYTES = 8,
    localparam int BANK_BITS  = $clog2(NUM_BANKS),
    localparam int WORD_SHIFT = $clog2(WORD_BYTES),
    localparam int BANK_W     = (BANK_BITS > 0) ? BANK_BITS : 1,
    localparam int OFF_W      = ADDR_W - WORD_SHIFT - BANK_BITS
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  offset
);

    logic [ADDR_W-1:0] word_addr;

    assign word_addr = byte_addr >> WORD_SHIFT;
    assign offset    = OFF_W'(word_addr >> BANK_BITS);

    generate
        if (BANK_BITS == 0) begin : g_single_bank
            logic unused_word;
            assign unused_word = ^word_addr;
            assign bank = '0;
        end else begin : g_interleaved
            assign bank = BANK_W'(word_addr);
        end
    endgenerate

endmodule

// File: rtl/sag_seq.sv
module sag_seq
    import sag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16,
    parameter int LEN_W    = 16,
    parameter int SIZE_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [SIZE_W-1:0]   cfg_size,
    input  logic                adv,
    output logic                valid,
    output logic [ADDR_W-1:0]   addr,
    output logic                last,
    output logic                done,
    output logic [STRIDE_W-1:0] stride
);

    typedef struct packed {
        seq_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   step;
        logic [LEN_W-1:0]    left;
        logic [STRIDE_W-1:0] stride;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.addr   = cfg_base;
            s_d.step   = ADDR_W'(cfg_stride) << cfg_size;
            s_d.left   = cfg_len;
            s_d.stride = cfg_stride;
            s_d.st     = (cfg_len == '0) ? SEQ_DONE : SEQ_RUN;
        end else if (s_q.st == SEQ_RUN && adv) begin
            if (s_q.left == LEN_W'(1)) begin
                s_d.st = SEQ_DONE;
            end else begin
                s_d.addr = s_q.addr + s_q.step;
                s_d.left = s_q.left - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, addr: '0, step: '0, left: '0, stride: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign valid  = (s_q.st == SEQ_RUN);
    assign done   = (s_q.st == SEQ_DONE);
    assign last   = valid && (s_q.left == LEN_W'(1));
    assign addr   = s_q.addr;
    assign stride = s_q.stride;

    // R4: an offered element and the done flag exclude each other
    a_r4_valid_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && done));

    // R3: without an advance the offered address holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !adv && !start) |=> (valid && $stable(addr)));

    // R3: an accepted non-last element moves the address by one step
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && adv && !last && !start) |=> (valid && addr == $past(addr) + $past(s_q.step)));

    // R4: taking the last element finishes the stream
    a_r4_last_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && adv && last && !start) |=> (done && !valid));

    // R4: done stays until a new start
    a_r4_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(addr)));

    // R2: a start always produces an element or done
    a_r2_start_acts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid || done));

endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int STRIDE_W   = 16,
    parameter int LEN_W      = 16,
    parameter int SIZE_W     = 2,
    parameter int NUM_BANKS  = 8,
    parameter int WORD_BYTES = 8,
    localparam int BANK_BITS  = $clog2(NUM_BANKS),
    localparam int WORD_SHIFT = $clog2(WORD_BYTES),
    localparam int BANK_W     = (BANK_BITS > 0) ? BANK_BITS : 1,
    localparam int OFF_W      = ADDR_W - WORD_SHIFT - BANK_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [SIZE_W-1:0]   cfg_size,
    input  logic                adv,
    output logic                elem_valid,
    output logic [ADDR_W-1:0]   elem_addr,
    output logic [BANK_W-1:0]   elem_bank,
    output logic [OFF_W-1:0]    elem_offset,
    output logic                elem_last,
    output logic                done,
    output logic [BANK_BITS:0]  banks_used,
    output logic [STRIDE_W-1:0] intra_stride
);

    logic [STRIDE_W-1:0] stride_q;

    sag_seq #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .LEN_W    (LEN_W),
        .SIZE_W   (SIZE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_base   (cfg_base),
        .cfg_stride (cfg_stride),
        .cfg_len    (cfg_len),
        .cfg_size   (cfg_size),
        .adv        (adv),
        .valid      (elem_valid),
        .addr       (elem_addr),
        .last       (elem_last),
        .done       (done),
        .stride     (stride_q)
    );

    sag_addr_split #(
        .ADDR_W     (ADDR_W),
        .NUM_BANKS  (NUM_BANKS),
        .WORD_BYTES (WORD_BYTES)
    ) u_split (
        .byte_addr (elem_addr),
        .bank      (elem_bank),
        .offset    (elem_offset)
    );

    sag_bank_geom #(
        .STRIDE_W  (STRIDE_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_geom (
        .stride       (stride_q),
        .banks_used   (banks_used),
        .intra_stride (intra_stride)
    );

    // R7: bank coverage is a power of two no larger than the bank count
    a_r7_banks_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(banks_used) == 1) && (banks_used <= (BANK_BITS + 1)'(NUM_BANKS)));

    // R7: a start changes the stride figures only through the loaded stride
    a_r7_geom_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(banks_used) && $stable(intra_stride)));

endmodule

// File: tb/stride_addr_gen_bench.sv
module stride_addr_gen_bench;

    localparam int ADDR_W = 32, STRIDE_W = 16, LEN_W = 16, SIZE_W = 2;
    localparam int NB = 8, WB = 8;

    logic clk = 0, rst_n = 0, start = 0, adv = 0;
    logic [ADDR_W-1:0]   cfg_base = '0;
    logic [STRIDE_W-1:0] cfg_stride = '0;
    logic [LEN_W-1:0]    cfg_len = '0;
    logic [SIZE_W-1:0]   cfg_size = '0;
    logic                elem_valid, elem_last, done;
    logic [ADDR_W-1:0]   elem_addr;
    logic [2:0]          elem_bank;
    logic [25:0]         elem_offset;
    logic [3:0]          banks_used;
    logic [STRIDE_W-1:0] intra_stride;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    stride_addr_gen u_stride_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_stride(cfg_stride), .cfg_len(cfg_len), .cfg_size(cfg_size), .adv(adv),
        .elem_valid(elem_valid), .elem_addr(elem_addr), .elem_bank(elem_bank),
        .elem_offset(elem_offset), .elem_last(elem_last), .done(done),
        .banks_used(banks_used), .intra_stride(intra_stride)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint gcd(input longint a, input longint b);
        longint x = a, y = b, t;
        while (y != 0) begin t = x % y; x = y; y = t; end
        return x;
    endfunction

    // behavioural reference model
    bit     m_valid = 0, m_done = 0;
    longint m_addr = 0, m_step = 0, m_left = 0, m_stride = 0;
    localparam longint MASK = (longint'(1) << ADDR_W) - 1;

    always @(posedge clk) begin
        longint word, g;
        if (!rst_n) begin
            m_valid = 0; m_done = 0; m_addr = 0; m_step = 0; m_left = 0; m_stride = 0;
        end else if (start) begin
            m_addr = cfg_base; m_stride = cfg_stride;
            m_step = (longint'(cfg_stride) * (longint'(1) << cfg_size)) & MASK;
            m_left = cfg_len;
            m_valid = (cfg_len != 0); m_done = (cfg_len == 0);
        end else if (m_valid && adv) begin
            if (m_left == 1) begin m_valid = 0; m_done = 1; end
            else begin m_addr = (m_addr + m_step) & MASK; m_left--; end
        end
        #1;
        chk("R2/R4 valid", elem_valid, m_valid);
        chk("R4 done", done, m_done);
        g = gcd(NB, m_stride);
        chk("R7 banks_used", banks_used, NB / g);
        chk("R7 intra_stride", intra_stride, m_stride / g);
        if (m_valid) begin
            word = m_addr / WB;
            chk("R3 addr", elem_addr, m_addr);
            chk("R4 last", elem_last, m_left == 1);
            chk("R6 bank", elem_bank, word % NB);
            chk("R6 offset", elem_offset, word / NB);
        end
    end

    task automatic go(input longint b, input longint s, input longint l, input longint z);
        @(negedge clk);
        start = 1; adv = 0;
        cfg_base = ADDR_W'(b); cfg_stride = STRIDE_W'(s); cfg_len = LEN_W'(l); cfg_size = SIZE_W'(z);
        @(negedge clk);
        start = 0;
    endtask

    task automatic drain(input int gap);
        int n = 0;
        while (!done) begin
            adv = (gap == 0) || (n % gap != 0);
            n++;
            @(negedge clk);
        end
        adv = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", elem_valid, 0);
        chk("R1 done in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 valid after reset", elem_valid, 0);
        chk("R1 done after reset", done, 0);

        go(32'h1000, 1, 5, 3);
        chk("R2 first addr", elem_addr, 32'h1000);
        drain(0);
        go(32'h2004, 2, 6, 2);  drain(2);
        go(32'h0040, 6, 4, 0);  drain(3);
        chk("R7 stride6 banks", banks_used, 4);
        chk("R7 stride6 intra", intra_stride, 3);
        go(32'h0100, 12, 4, 3); drain(0);
        go(32'h0100, 5, 9, 3);  drain(4);
        go(32'h0800, 8, 3, 3);  drain(0);

        // R8: zero stride repeats the base
        go(32'h3000, 0, 3, 3);
        chk("R7 stride0 banks", banks_used, 1);
        chk("R7 stride0 intra", intra_stride, 0);
        for (int i = 0; i < 3; i++) begin
            chk("R8 repeated base", elem_addr, 32'h3000);
            chk("R8 still valid", elem_valid, 1);
            adv = 1; @(negedge clk);
        end
        adv = 0;
        chk("R8 done after len", done, 1);

        // R10: advances while done are ignored
        for (int i = 0; i < 3; i++) begin
            adv = 1; @(negedge clk);
            chk("R10 done held", done, 1);
            chk("R10 addr held", elem_addr, 32'h3000);
        end
        adv = 0;

        // R5: zero length
        go(32'h4000, 1, 0, 3);
        chk("R5 done", done, 1);
        chk("R5 valid", elem_valid, 0);

        // R9: start beats a same-cycle advance
        go(32'h5000, 1, 10, 3);
        adv = 1; repeat (3) @(negedge clk);
        start = 1; cfg_base = 32'h6000; cfg_stride = 3; cfg_len = 4; cfg_size = 1;
        @(negedge clk);
        start = 0; adv = 0;
        chk("R9 restart addr", elem_addr, 32'h6000);
        chk("R9 restart last", elem_last, 0);
        drain(0);

        // R3: address wraps at the top
        go(32'hFFFF_FFF0, 1, 4, 3);
        drain(0);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule